// File: doc/BRIEF.md
# Register-Mapped ADC Conversion Controller

This block sits between a simple 32-bit register bus and an 8-channel, 10-bit successive-approximation converter core. Software uses it in a fixed order. It turns the converter on through a power register. It picks a channel and a mode in the configuration word and raises a start request. It then polls a completion flag and reads the result, together with the number of the channel that result came from. The controller alone decides when the core may be started. It issues a start pulse only once a settling count has run out after power-up. A request made earlier is kept and released by itself when that count expires.

Two conversion modes exist. In single mode the start bit clears when the conversion finishes. In continuous mode the controller starts the next conversion on the cycle after each completion, and keeps doing so until software clears the start bit. The channel recorded with each result is the one issued to the core. It therefore stays correct when software has already moved the configuration on to another channel.

Top module: `adc_ctrl`

## Requirements
- R1: After reset every register reads zero, the power output is low and no start pulse is given.
- R2: Bit 0 of the power register (offset 0x10) drives the converter power output and reads back.
- R3: With the default settling count of 8, the first start pulse appears in the clock cycle after the 8th rising edge that follows the edge on which power was written to 1. A start written during that window is held and is then issued automatically.
- R4: A configuration write with the start bit (bit 4) set while power is off leaves the start bit reading 0 and causes no start pulse. Channel (bits [2:0]) and single mode (bit 5) are still stored.
- R5: A start pulse lasts one cycle and carries the configured channel. It is only given when no conversion is in flight and power is on.
- R6: On completion the data register (0x04) holds the 10-bit result in bits [9:0] with the upper bits zero. The flag register (0x08) bit 0 reads 1. The sampled-channel register (0x0C) bits [2:0] gives the channel that was issued, even if the configured channel has since changed.
- R7: Writing the start bit clears the completion flag. If that write lands in the same cycle as a completion, the result and count are still taken, the flag stays 0 and the new request is queued.
- R8: In single mode the start bit reads 0 after completion. In continuous mode (bit 5 = 0) the next start pulse follows on the cycle after completion. A configuration write with bit 4 = 0 cancels the request and stops re-arming.
- R9: Writing power bit 0 = 0 aborts any conversion and clears the start bit, the request and the flag. A completion in that same cycle is discarded, so data and count do not change. The settling count starts again at the next power-up.
- R10: The count register (0x20) rises by one for each accepted completion. A completion pulse with no conversion in flight is ignored.
- R11: Reads return data one cycle after the read request. Undefined offsets read zero. Writes to undefined or read-only offsets change nothing.
- R12: The debug register (0x14) reports request pending in bit 0, conversion in flight in bit 1 and settling finished in bit 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| conv_pwr | output | 1 | Converter power enable |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_chan | output | 3 | Channel presented with the start pulse |
| conv_done | input | 1 | Completion pulse from the converter |
| conv_result | input | 10 | Conversion result, valid with conv_done |

## Verification
Two events can fall in the same cycle and need care. One is a completion arriving while software writes a new start or writes power off. The other is a continuous-mode re-arm meeting a write that clears the start bit. The bench waits until it sees the completion pulse from its converter model. It then places the write in that same cycle. After that it reads the flag, the count, the data and the sampled channel. It compares what it reads against the values the requirements predict: the result taken and the flag left clear for a start, or the result discarded for an abort. A behavioural model checks the read data and the start pulse on every cycle as well.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

  // register byte offsets
  localparam int unsigned OFS_CFG  = 32'h00;
  localparam int unsigned OFS_DATA = 32'h04;
  localparam int unsigned OFS_EOC  = 32'h08;
  localparam int unsigned OFS_SAMP = 32'h0C;
  localparam int unsigned OFS_PWR  = 32'h10;
  localparam int unsigned OFS_DBG  = 32'h14;
  localparam int unsigned OFS_CNT  = 32'h20;

  // configuration word bit positions
  localparam int unsigned CFG_RUN_BIT    = 4;
  localparam int unsigned CFG_SINGLE_BIT = 5;

  function automatic logic [31:0] pack_cfg(input logic [7:0] chan, input logic run,
                                           input logic single);
    logic [31:0] w;
    w = 32'(chan);
    w[CFG_RUN_BIT] = run;
    w[CFG_SINGLE_BIT] = single;
    return w;
  endfunction

  function automatic logic [31:0] pack_dbg(input logic pend, input logic busy,
                                           input logic settled);
    return {29'd0, settled, busy, pend};
  endfunction

endpackage

// File: rtl/adc_ctrl_settle.sv
module adc_ctrl_settle #(
  parameter int unsigned SETTLE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_on,
  output logic settled
);
  localparam int unsigned CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!pwr_on)        cnt <= '0;
    else if (cnt != LIMIT)   cnt <= cnt + 1'b1;
  end

  assign settled = pwr_on && (cnt == LIMIT);
endmodule

// File: rtl/adc_ctrl_seq.sv
module adc_ctrl_seq #(
  parameter int unsigned CH_W  = 3,
  parameter int unsigned RES_W = 10,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             settled,
  input  logic [CH_W-1:0]  cfg_chan,
  input  logic             cfg_single,
  input  logic             start_wr,
  input  logic             stop_wr,
  input  logic             abort,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  output logic             issue,
  output logic             accept_done,
  output logic             run,
  output logic             pend,
  output logic             busy,
  output logic             eoc,
  output logic [CH_W-1:0]  samp_chan,
  output logic [RES_W-1:0] data,
  output logic [CNT_W-1:0] count
);
  logic [CH_W-1:0] issued_chan;

  assign issue       = pend && settled && !busy;
  assign accept_done = conv_done && busy && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; pend <= 1'b0; busy <= 1'b0; eoc <= 1'b0;
      issued_chan <= '0; samp_chan <= '0; data <= '0; count <= '0;
    end else if (abort) begin
      run <= 1'b0; pend <= 1'b0; busy <= 1'b0; eoc <= 1'b0;
    end else begin
      if (accept_done) begin
        busy      <= 1'b0;
        eoc       <= 1'b1;
        data      <= conv_result;
        samp_chan <= issued_chan;
        count     <= count + 1'b1;
        if (cfg_single) run  <= 1'b0;
        else if (run)   pend <= 1'b1;
      end
      if (issue) begin
        busy        <= 1'b1;
        pend        <= 1'b0;
        issued_chan <= cfg_chan;
      end
      if (start_wr) begin
        run  <= 1'b1;
        pend <= 1'b1;
        eoc  <= 1'b0;
      end
      if (stop_wr) begin
        run  <= 1'b0;
        pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
  import adc_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CH_W   = 3,
  parameter int unsigned RES_W  = 10,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              run,
  input  logic              pend,
  input  logic              busy,
  input  logic              eoc,
  input  logic              settled,
  input  logic [CH_W-1:0]   samp_chan,
  input  logic [RES_W-1:0]  data,
  input  logic [CNT_W-1:0]  count,
  output logic [CH_W-1:0]   cfg_chan,
  output logic              cfg_single,
  output logic              pwr_on,
  output logic              start_wr,
  output logic              stop_wr,
  output logic              abort
);
  logic wr_cfg, wr_pwr;
  logic [DATA_W-1:0] rd_val;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata;
  assign wr_cfg   = bus_wr && (bus_addr == ADDR_W'(OFS_CFG));
  assign wr_pwr   = bus_wr && (bus_addr == ADDR_W'(OFS_PWR));
  assign start_wr = wr_cfg && bus_wdata[CFG_RUN_BIT] && pwr_on;
  assign stop_wr  = wr_cfg && !bus_wdata[CFG_RUN_BIT];
  assign abort    = wr_pwr && !bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_chan <= '0; cfg_single <= 1'b0; pwr_on <= 1'b0;
    end else begin
      if (wr_cfg) begin
        cfg_chan   <= bus_wdata[CH_W-1:0];
        cfg_single <= bus_wdata[CFG_SINGLE_BIT];
      end
      if (wr_pwr) pwr_on <= bus_wdata[0];
    end
  end

  always_comb begin
    case (bus_addr)
      ADDR_W'(OFS_CFG):  rd_val = DATA_W'(pack_cfg(8'(cfg_chan), run, cfg_single));
      ADDR_W'(OFS_DATA): rd_val = DATA_W'(data);
      ADDR_W'(OFS_EOC):  rd_val = DATA_W'(eoc);
      ADDR_W'(OFS_SAMP): rd_val = DATA_W'(samp_chan);
      ADDR_W'(OFS_PWR):  rd_val = DATA_W'(pwr_on);
      ADDR_W'(OFS_DBG):  rd_val = DATA_W'(pack_dbg(pend, busy, settled));
      ADDR_W'(OFS_CNT):  rd_val = DATA_W'(count);
      default:           rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end
endmodule

// File: rtl/adc_ctrl.sv
module adc_ctrl #(
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned CH_W          = 3,
  parameter int unsigned RES_W         = 10,
  parameter int unsigned CNT_W         = 16,
  parameter int unsigned SETTLE_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              conv_pwr,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_chan,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result
);
  logic pwr_on, settled, issue, accept_done, abort, start_wr, stop_wr;
  logic run, pend, busy, eoc, cfg_single;
  logic [CH_W-1:0]  cfg_chan, samp_chan;
  logic [RES_W-1:0] data;
  logic [CNT_W-1:0] count;

  adc_ctrl_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CH_W(CH_W), .RES_W(RES_W), .CNT_W(CNT_W)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .run(run), .pend(pend), .busy(busy),
    .eoc(eoc), .settled(settled), .samp_chan(samp_chan), .data(data), .count(count),
    .cfg_chan(cfg_chan), .cfg_single(cfg_single), .pwr_on(pwr_on), .start_wr(start_wr),
    .stop_wr(stop_wr), .abort(abort)
  );

  adc_ctrl_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) settle_i (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .settled(settled)
  );

  adc_ctrl_seq #(.CH_W(CH_W), .RES_W(RES_W), .CNT_W(CNT_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .settled(settled), .cfg_chan(cfg_chan),
    .cfg_single(cfg_single), .start_wr(start_wr), .stop_wr(stop_wr), .abort(abort),
    .conv_done(conv_done), .conv_result(conv_result), .issue(issue),
    .accept_done(accept_done), .run(run), .pend(pend), .busy(busy), .eoc(eoc),
    .samp_chan(samp_chan), .data(data), .count(count)
  );

  assign conv_pwr   = pwr_on;
  assign conv_start = issue;
  assign conv_chan  = cfg_chan;
endmodule

// File: rtl/adc_ctrl_chk.sv
module adc_ctrl_chk
  import adc_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned MIN_WAIT = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_pwr,
  input logic              conv_start,
  input logic              busy,
  input logic              pend,
  input logic              eoc,
  input logic              accept_done,
  input logic              abort,
  input logic              start_wr,
  input logic [CNT_W-1:0]  count,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata
);
  localparam int unsigned WW = $clog2(MIN_WAIT + 1);
  logic [WW-1:0] on_cyc;
  logic mapped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          on_cyc <= '0;
    else if (!conv_pwr)                  on_cyc <= '0;
    else if (on_cyc != WW'(MIN_WAIT))    on_cyc <= on_cyc + 1'b1;
  end

  assign mapped = (bus_addr == ADDR_W'(OFS_CFG))  || (bus_addr == ADDR_W'(OFS_DATA)) ||
                  (bus_addr == ADDR_W'(OFS_EOC))  || (bus_addr == ADDR_W'(OFS_SAMP)) ||
                  (bus_addr == ADDR_W'(OFS_PWR))  || (bus_addr == ADDR_W'(OFS_DBG))  ||
                  (bus_addr == ADDR_W'(OFS_CNT));

  // R3
  settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (on_cyc == WW'(MIN_WAIT)));

  // R5
  issue_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (!busy && conv_pwr));

  // R5
  issue_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !abort) |=> busy);

  // R6
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_done && !start_wr) |=> eoc);

  // R9
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !pend && !eoc && !conv_pwr));

  // R10
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_done |=> (count == $past(count) + 1'b1));

  // R11
  hole_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !mapped) |=> (bus_rdata == '0));
endmodule

bind adc_ctrl adc_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .conv_pwr(conv_pwr), .conv_start(conv_start), .busy(busy),
  .pend(pend), .eoc(eoc), .accept_done(accept_done), .abort(abort), .start_wr(start_wr),
  .count(count), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/adc_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_ctrl_tb_top;
  localparam int SETTLE = 8;
  localparam int LAT    = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic        bus_wr = 0, bus_rd = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        conv_pwr, conv_start;
  logic [2:0]  conv_chan;
  logic        s_done, stray;
  logic [9:0]  conv_result;
  logic        conv_done;
  assign conv_done = s_done | stray;

  adc_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_pwr(conv_pwr),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
    .conv_result(conv_result)
  );

  int checks = 0, fails = 0, start_seen = 0;
  bit finished = 0, mon_on = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural converter: answers LAT cycles after a start
  int s_cnt, s_seq;
  logic [2:0] s_ch;
  always @(posedge clk) begin
    if (!rst_n || !conv_pwr) begin
      s_cnt <= 0; s_done <= 0;
      if (!rst_n) begin conv_result <= 0; s_seq <= 0; s_ch <= 0; end
    end else if (conv_start) begin
      s_cnt <= LAT; s_ch <= conv_chan; s_done <= 0;
    end else if (s_cnt == 1) begin
      s_done <= 1; conv_result <= 10'(s_ch * 97 + s_seq * 13 + 5);
      s_seq <= s_seq + 1; s_cnt <= 0;
    end else begin
      s_done <= 0;
      if (s_cnt > 1) s_cnt <= s_cnt - 1;
    end
  end

  // reference model
  bit m_pwr, m_pend, m_busy, m_eoc, m_run, m_single;
  int m_cnt, m_chan, m_ichan, m_schan, m_data, m_count;
  logic [31:0] m_rd;

  function automatic bit m_issue();
    return m_pend && m_pwr && (m_cnt == SETTLE) && !m_busy;
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return 32'(m_chan) | (32'(m_run) << 4) | (32'(m_single) << 5);
      8'h04: return 32'(m_data);
      8'h08: return 32'(m_eoc);
      8'h0C: return 32'(m_schan);
      8'h10: return 32'(m_pwr);
      8'h14: return 32'(m_pend) | (32'(m_busy) << 1) | (32'(m_pwr && m_cnt == SETTLE) << 2);
      8'h20: return 32'(m_count) & 32'hFFFF;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin : mdl
    bit o_pwr, o_busy, o_run, o_single, iss, dn, ab, sw, pw, cw;
    int o_chan;
    if (!rst_n) begin
      m_pwr = 0; m_pend = 0; m_busy = 0; m_eoc = 0; m_run = 0; m_single = 0;
      m_cnt = 0; m_chan = 0; m_ichan = 0; m_schan = 0; m_data = 0; m_count = 0; m_rd = 0;
    end else begin
      o_pwr = m_pwr; o_busy = m_busy; o_run = m_run; o_single = m_single; o_chan = m_chan;
      iss = m_issue();
      cw = bus_wr && bus_addr == 8'h00;
      pw = bus_wr && bus_addr == 8'h10;
      ab = pw && !bus_wdata[0];
      sw = cw && bus_wdata[4] && o_pwr;
      dn = conv_done && o_busy && !ab;
      if (bus_rd) m_rd = m_read(bus_addr);
      m_cnt = !o_pwr ? 0 : (m_cnt < SETTLE ? m_cnt + 1 : m_cnt);
      if (pw) m_pwr = bus_wdata[0];
      if (cw) begin m_chan = int'(bus_wdata[2:0]); m_single = bus_wdata[5]; end
      if (ab) begin
        m_run = 0; m_pend = 0; m_busy = 0; m_eoc = 0;
      end else begin
        if (dn) begin
          m_busy = 0; m_eoc = 1; m_data = int'(conv_result); m_schan = m_ichan; m_count++;
          if (o_single) m_run = 0;
          else if (o_run) m_pend = 1;
        end
        if (iss) begin m_busy = 1; m_pend = 0; m_ichan = o_chan; end
        if (sw) begin m_run = 1; m_pend = 1; m_eoc = 0; end
        if (cw && !bus_wdata[4]) begin m_run = 0; m_pend = 0; end
      end
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (mon_on) begin
      chk("R11 read data vs model", bus_rdata, m_rd);
      chk("R3 start pulse vs model", 32'(conv_start), 32'(m_issue()));
      chk("R2 power output vs model", 32'(conv_pwr), 32'(m_pwr));
      if (conv_start) begin
        start_seen++;
        chk("R5 channel with start", 32'(conv_chan), 32'(m_chan));
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus_rd = 1; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_rd = 0;
    chk(tag, bus_rdata, exp);
  endtask

  logic [31:0] last_res;

  task automatic wait_done_pulse();
    int n = 0;
    while (!conv_done && n < 100) begin @(negedge clk); n++; end
    if (n >= 100) chk("R6 completion timeout", 0, 1);
    last_res = 32'(conv_result);
  endtask

  task automatic wait_done();
    wait_done_pulse();
    @(negedge clk);
  endtask

  task automatic settle_measure(input string tag);
    int n = 1;
    while (!conv_start && n < 40) begin @(negedge clk); n++; end
    chk(tag, n, SETTLE);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired (R1..) actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    int s0;
    logic [31:0] keep;
    stray = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    mon_on = 1;

    // R1 reset values
    rd(8'h00, 0, "R1 cfg reset");
    rd(8'h04, 0, "R1 data reset");
    rd(8'h08, 0, "R1 flag reset");
    rd(8'h0C, 0, "R1 sampled reset");
    rd(8'h10, 0, "R1 power reset");
    rd(8'h14, 0, "R1 debug reset");
    rd(8'h20, 0, "R1 count reset");
    chk("R1 power low", 32'(conv_pwr), 0);

    // R4 start while unpowered
    wr(8'h00, 32'h33);
    rd(8'h00, 32'h23, "R4 start ignored when off");
    chk("R4 no start pulse", start_seen, 0);

    // R2 / R3 power-up and held start
    wr(8'h10, 1);
    wr(8'h00, 32'h35);
    settle_measure("R3 start after settle window");
    chk("R5 channel 5 issued", 32'(conv_chan), 5);
    chk("R2 power output high", 32'(conv_pwr), 1);
    wait_done();
    rd(8'h08, 1, "R6 flag set");
    rd(8'h04, last_res, "R6 data value");
    rd(8'h0C, 5, "R6 sampled channel");
    rd(8'h00, 32'h25, "R8 single start self-clear");
    rd(8'h20, 1, "R10 count one");
    rd(8'h10, 1, "R2 power readback");

    // R7 start clears flag; R6 sampled vs requested channel
    wr(8'h00, 32'h32);
    rd(8'h08, 0, "R7 flag cleared by start");
    wr(8'h00, 32'h27);
    wait_done();
    rd(8'h0C, 2, "R6 sampled differs from requested");
    rd(8'h00, 32'h27, "R8 cfg after stop");
    rd(8'h04, last_res, "R6 data second");

    // R7 start write colliding with completion
    wr(8'h00, 32'h31);
    wait_done_pulse();
    keep = last_res;
    wr(8'h00, 32'h30);
    rd(8'h08, 0, "R7 flag stays clear on collision");
    rd(8'h20, 3, "R7 count taken on collision");
    rd(8'h04, keep, "R7 data taken on collision");
    rd(8'h0C, 1, "R7 sampled on collision");
    wait_done();
    rd(8'h0C, 0, "R7 queued conversion channel");
    rd(8'h08, 1, "R7 flag after queued");
    rd(8'h20, 4, "R10 count four");

    // R8 continuous mode
    wr(8'h00, 32'h14);
    wait_done();
    chk("R8 continuous re-arm next cycle", 32'(conv_start), 1);
    wr(8'h00, 32'h04);
    wait_done();
    keep = last_res;
    s0 = start_seen;
    repeat (20) @(negedge clk);
    chk("R8 stop ends re-arming", start_seen - s0, 0);
    rd(8'h00, 32'h04, "R8 cfg after stop");
    rd(8'h20, 6, "R10 count six");

    // R9 abort colliding with completion
    wr(8'h00, 32'h36);
    wait_done_pulse();
    wr(8'h10, 0);
    chk("R9 power low after abort", 32'(conv_pwr), 0);
    rd(8'h20, 6, "R9 count unchanged");
    rd(8'h08, 0, "R9 flag cleared");
    rd(8'h00, 32'h26, "R9 start bit cleared");
    rd(8'h04, keep, "R9 data unchanged");
    rd(8'h14, 0, "R9 debug idle");
    wr(8'h10, 1);
    wr(8'h00, 32'h31);
    settle_measure("R9 settle restarts");
    wait_done();

    // R10 stray completion
    stray = 1;
    @(negedge clk);
    stray = 0;
    rd(8'h20, 7, "R10 stray completion ignored");
    rd(8'h08, 1, "R10 flag kept");

    // R11 map holes and read-only targets
    rd(8'h18, 0, "R11 hole 0x18");
    rd(8'h02, 0, "R11 unaligned");
    rd(8'h24, 0, "R11 hole 0x24");
    wr(8'h20, 32'hFFFF);
    wr(8'h08, 0);
    wr(8'h04, 32'h3FF);
    wr(8'h0C, 7);
    wr(8'h18, 32'hFFFFFFFF);
    rd(8'h20, 7, "R11 count read-only");
    rd(8'h08, 1, "R11 flag read-only");
    rd(8'h04, last_res, "R11 data read-only");
    rd(8'h0C, 1, "R11 sampled read-only");
    rd(8'h00, 32'h21, "R11 cfg untouched");
    rd(8'h10, 1, "R11 power untouched");

    // R12 debug view
    wr(8'h10, 0);
    wr(8'h10, 1);
    wr(8'h00, 32'h30);
    rd(8'h14, 32'h1, "R12 pending in window");
    while (!conv_start) @(negedge clk);
    @(negedge clk);
    rd(8'h14, 32'h6, "R12 busy and settled");
    wait_done();
    rd(8'h20, 8, "R10 count eight");

    finish_run();
  end
endmodule